// File: doc/BRIEF.md
# Pin-Override GPIO Port

An 8-bit general-purpose I/O port with a small synchronous register bus. Software sets each pin's output value and direction, and each pin's pullup, slew-rate and drive-strength pad controls. The port drives a set of pad control outputs and reads back the pin level through a two-flop synchronizer.

Any pin can be claimed by a shared peripheral. Three kinds of claim exist. A timer channel takes the pin's direction, and when it drives the pin it also takes the output value. A keyboard-interrupt enable holds the pin as an input. An oscillator enable removes two fixed pins (5 and 6) from all port control. A per-pin arbitration stage resolves these claims in a fixed priority order. The timer, keyboard and oscillator logic lie outside the block and are seen only as enable, direction and data inputs.

Top module: `gpio_ovr_port`

## Requirements
- R1: After reset every register reads zero. Every pad output enable, output data, pullup, slew and drive output is 0, so every pin is an input with its pullup off.
- R2: A write with `we_i` high lands at the next rising clock edge. The register selected by `addr_i` is: 0 output data, 1 direction (1 = output), 2 pullup enable, 3 slew enable, 4 drive-strength select. Addresses 1 to 4 read back the stored value. Writes to addresses 5 to 7 change nothing, and reads of those addresses return 0.
- R3: On a pin with no active claim, `pad_oe_o` equals the direction bit and `pad_do_o` equals the data-register bit.
- R4: On a pin not held by the oscillator, `pad_pu_o`, `pad_slew_o` and `pad_drv_o` equal the bits of registers 2, 3 and 4, whatever timer or keyboard claims are active.
- R5: With `tmr_en_i[i]` set and no higher claim, `pad_oe_o[i]` equals `tmr_oe_i[i]` and the direction bit has no effect.
- R6: With `tmr_en_i[i]` and `tmr_oe_i[i]` set and no higher claim, `pad_do_o[i]` equals `tmr_do_i[i]` and the data bit has no effect. In every other case outside oscillator hold, `pad_do_o[i]` is the data bit.
- R7: With `kbi_en_i[i]` set and no oscillator hold, `pad_oe_o[i]` is 0, whatever the direction bit or timer claim says.
- R8: With `osc_en_i` high, pins 5 and 6 have output enable, output data, pullup, slew and drive all at 0. The stored registers are left unchanged, and the other pins are unaffected.
- R9: Reading address 0 returns, per pin, the data-register bit when `pad_oe_o` is 1. When `pad_oe_o` is 0 it returns `pin_i` as sampled two rising edges earlier.
- R10: Claims rank oscillator first, then keyboard interrupt, then timer, then the port registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register select |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| pin_i | input | 8 | Pad input level |
| tmr_en_i | input | 8 | Timer channel claims pin |
| tmr_oe_i | input | 8 | Timer drives pin as output |
| tmr_do_i | input | 8 | Timer output value |
| kbi_en_i | input | 8 | Keyboard-interrupt input enable |
| osc_en_i | input | 1 | External oscillator enable (pins 5, 6) |
| pad_oe_o | output | 8 | Pad output enable |
| pad_do_o | output | 8 | Pad output data |
| pad_pu_o | output | 8 | Pad pullup enable |
| pad_slew_o | output | 8 | Pad slew-rate enable |
| pad_drv_o | output | 8 | Pad drive-strength select |

## Verification
The bench piles claims on the same pin to test the priority order. A keyboard enable combined with a driving timer must keep the pin an input. A design that checked the timer first would drive the pad against the keyboard source. With the oscillator on, the bench writes ones to every pad-control register and requires pins 5 and 6 to stay dark, which catches a design that forgets to mask the pullup or drive bits. Data readback is compared against the pin history two edges back on input pins and against the stored value on output pins, so a missing or extra synchronizer stage or a wrong mux select shows up directly.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;
  localparam int unsigned ADDR_W   = 3;
  localparam int unsigned NUM_REGS = 5;

  typedef enum logic [ADDR_W-1:0] {
    REG_DATA  = 3'd0,
    REG_DIR   = 3'd1,
    REG_PULL  = 3'd2,
    REG_SLEW  = 3'd3,
    REG_DRIVE = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/gpio_ovr_regs.sv
module gpio_ovr_regs
  import gpio_ovr_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [WIDTH-1:0]  wdata_i,
  output logic [WIDTH-1:0]  data_o,
  output logic [WIDTH-1:0]  dir_o,
  output logic [WIDTH-1:0]  pull_o,
  output logic [WIDTH-1:0]  slew_o,
  output logic [WIDTH-1:0]  drv_o
);
  logic [WIDTH-1:0] bank_q [NUM_REGS];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                bank_q[r] <= '0;
      else if (we_i && addr_i == ADDR_W'(r))     bank_q[r] <= wdata_i;
    end
  end

  assign data_o = bank_q[REG_DATA];
  assign dir_o  = bank_q[REG_DIR];
  assign pull_o = bank_q[REG_PULL];
  assign slew_o = bank_q[REG_SLEW];
  assign drv_o  = bank_q[REG_DRIVE];

  p_write_lands_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == REG_DIR) |=> (dir_o == $past(wdata_i)));
  p_hold_no_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(data_o) && $stable(pull_o));
endmodule

// File: rtl/gpio_ovr_sync.sv
module gpio_ovr_sync #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] pin_sync_o
);
  logic [WIDTH-1:0] meta_q, sync_q;
  logic             warm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
      warm_q <= 1'b0;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
      warm_q <= 1'b1;
    end
  end

  assign pin_sync_o = sync_q;

  p_first_stage_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm_q |-> meta_q == $past(pin_i));
  p_second_stage_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm_q |-> sync_q == $past(meta_q));
endmodule

// File: rtl/gpio_ovr_arb.sv
module gpio_ovr_arb #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned OSC_A = 5,
  parameter int unsigned OSC_B = 6
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic [WIDTH-1:0] dir_i,
  input  logic [WIDTH-1:0] pull_i,
  input  logic [WIDTH-1:0] slew_i,
  input  logic [WIDTH-1:0] drv_i,
  input  logic [WIDTH-1:0] tmr_en_i,
  input  logic [WIDTH-1:0] tmr_oe_i,
  input  logic [WIDTH-1:0] tmr_do_i,
  input  logic [WIDTH-1:0] kbi_en_i,
  input  logic             osc_en_i,
  output logic [WIDTH-1:0] oe_o,
  output logic [WIDTH-1:0] do_o,
  output logic [WIDTH-1:0] pu_o,
  output logic [WIDTH-1:0] slew_o,
  output logic [WIDTH-1:0] drv_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    localparam bit OscPin = (i == OSC_A) || (i == OSC_B);
    logic osc_hold;
    assign osc_hold = OscPin & osc_en_i;

    // priority: oscillator > keyboard > timer > port registers
    always_comb begin
      oe_o[i]   = dir_i[i];
      do_o[i]   = data_i[i];
      pu_o[i]   = pull_i[i];
      slew_o[i] = slew_i[i];
      drv_o[i]  = drv_i[i];
      if (osc_hold) begin
        oe_o[i]   = 1'b0;
        do_o[i]   = 1'b0;
        pu_o[i]   = 1'b0;
        slew_o[i] = 1'b0;
        drv_o[i]  = 1'b0;
      end else if (kbi_en_i[i]) begin
        oe_o[i]   = 1'b0;
      end else if (tmr_en_i[i]) begin
        oe_o[i]   = tmr_oe_i[i];
        if (tmr_oe_i[i]) do_o[i] = tmr_do_i[i];
      end
    end
  end
endmodule

// File: rtl/gpio_ovr_port.sv
module gpio_ovr_port
  import gpio_ovr_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned OSC_A = 5,
  parameter int unsigned OSC_B = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [WIDTH-1:0]  wdata_i,
  output logic [WIDTH-1:0]  rdata_o,
  input  logic [WIDTH-1:0]  pin_i,
  input  logic [WIDTH-1:0]  tmr_en_i,
  input  logic [WIDTH-1:0]  tmr_oe_i,
  input  logic [WIDTH-1:0]  tmr_do_i,
  input  logic [WIDTH-1:0]  kbi_en_i,
  input  logic              osc_en_i,
  output logic [WIDTH-1:0]  pad_oe_o,
  output logic [WIDTH-1:0]  pad_do_o,
  output logic [WIDTH-1:0]  pad_pu_o,
  output logic [WIDTH-1:0]  pad_slew_o,
  output logic [WIDTH-1:0]  pad_drv_o
);
  logic [WIDTH-1:0] data_q, dir_q, pull_q, slew_q, drv_q, pin_sync;

  gpio_ovr_regs #(.WIDTH(WIDTH)) u_regs (
    .clk_i, .rst_ni, .addr_i, .we_i, .wdata_i,
    .data_o(data_q), .dir_o(dir_q), .pull_o(pull_q),
    .slew_o(slew_q), .drv_o(drv_q)
  );

  gpio_ovr_sync #(.WIDTH(WIDTH)) u_sync (
    .clk_i, .rst_ni, .pin_i, .pin_sync_o(pin_sync)
  );

  gpio_ovr_arb #(.WIDTH(WIDTH), .OSC_A(OSC_A), .OSC_B(OSC_B)) u_arb (
    .data_i(data_q), .dir_i(dir_q), .pull_i(pull_q), .slew_i(slew_q),
    .drv_i(drv_q), .tmr_en_i, .tmr_oe_i, .tmr_do_i, .kbi_en_i, .osc_en_i,
    .oe_o(pad_oe_o), .do_o(pad_do_o), .pu_o(pad_pu_o),
    .slew_o(pad_slew_o), .drv_o(pad_drv_o)
  );

  always_comb begin
    case (addr_i)
      REG_DATA:  rdata_o = (pad_oe_o & data_q) | (~pad_oe_o & pin_sync);
      REG_DIR:   rdata_o = dir_q;
      REG_PULL:  rdata_o = pull_q;
      REG_SLEW:  rdata_o = slew_q;
      REG_DRIVE: rdata_o = drv_q;
      default:   rdata_o = '0;
    endcase
  end

  p_reset_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (pad_oe_o == '0 && pad_pu_o == '0 && pad_drv_o == '0));
  p_kbi_input_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kbi_en_i & pad_oe_o) == '0);
  p_osc_dark_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    osc_en_i |-> !(pad_oe_o[OSC_A] | pad_do_o[OSC_A] | pad_pu_o[OSC_A]
                   | pad_slew_o[OSC_A] | pad_drv_o[OSC_A] | pad_oe_o[OSC_B]
                   | pad_pu_o[OSC_B] | pad_drv_o[OSC_B]));
  for (genvar i = 0; i < WIDTH; i++) begin : g_chk
    p_timer_drive_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tmr_en_i[i] && tmr_oe_i[i] && !kbi_en_i[i] && !(osc_en_i && (i == OSC_A || i == OSC_B)))
        |-> (pad_oe_o[i] && pad_do_o[i] == tmr_do_i[i]));
  end
endmodule

// File: tb/gpio_ovr_port_bench.sv
module gpio_ovr_port_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       we = 1'b0;
  logic [7:0] wdata = '0, pin = '0, t_en = '0, t_oe = '0, t_do = '0, k_en = '0;
  logic       osc = 1'b0;
  logic [7:0] rdata, oe, dout, pu, sl, dr;

  int checks = 0, errors = 0, cyc = 0;
  logic [7:0] m_reg [5];
  logic [7:0] hist [$];

  always #2 clk = ~clk;

  gpio_ovr_port u_gpio_ovr_port (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .pin_i(pin), .tmr_en_i(t_en), .tmr_oe_i(t_oe),
    .tmr_do_i(t_do), .kbi_en_i(k_en), .osc_en_i(osc), .pad_oe_o(oe),
    .pad_do_o(dout), .pad_pu_o(pu), .pad_slew_o(sl), .pad_drv_o(dr)
  );

  // reference model state
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < 5; r++) m_reg[r] = '0;
      hist = '{8'h00, 8'h00};
    end else begin
      if (we && addr < 3'd5) m_reg[addr] = wdata;
      hist.push_front(pin);
      void'(hist.pop_back());
    end
  end

  task automatic cmp(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic check_all();
    logic [7:0] e_oe, e_do, e_pu, e_sl, e_dr, e_rd;
    for (int i = 0; i < 8; i++) begin
      bit oh = osc && (i == 5 || i == 6);
      e_pu[i] = oh ? 1'b0 : m_reg[2][i];
      e_sl[i] = oh ? 1'b0 : m_reg[3][i];
      e_dr[i] = oh ? 1'b0 : m_reg[4][i];
      if (oh)             begin e_oe[i] = 0; e_do[i] = 0; end
      else if (k_en[i])   begin e_oe[i] = 0; e_do[i] = m_reg[0][i]; end
      else if (t_en[i])   begin e_oe[i] = t_oe[i]; e_do[i] = t_oe[i] ? t_do[i] : m_reg[0][i]; end
      else                begin e_oe[i] = m_reg[1][i]; e_do[i] = m_reg[0][i]; end
    end
    case (addr)
      3'd0: for (int i = 0; i < 8; i++) e_rd[i] = e_oe[i] ? m_reg[0][i] : hist[1][i];
      3'd1, 3'd2, 3'd3, 3'd4: e_rd = m_reg[addr];
      default: e_rd = '0;
    endcase
    cmp("R3/R5/R7/R8/R10", "pad_oe", oe, e_oe);
    cmp("R3/R6/R8/R10", "pad_do", dout, e_do);
    cmp("R4/R8", "pad_pu", pu, e_pu);
    cmp("R4/R8", "pad_slew", sl, e_sl);
    cmp("R4/R8", "pad_drv", dr, e_dr);
    cmp("R2/R9", "rdata", rdata, e_rd);
  endtask

  task automatic step(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      check_all();
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    step(1);
    we = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < 5; r++) m_reg[r] = '0;
    hist = '{8'h00, 8'h00};
    pin = 8'hA5;
    #9 rst_n = 1'b1;
    // R1: reset state
    step(1);
    cmp("R1", "oe after reset", oe, 8'h00);
    cmp("R1", "pullup after reset", pu, 8'h00);
    // R9: synchronized readback of inputs
    addr = 3'd0; step(3);
    cmp("R9", "input readback", rdata, 8'hA5);
    // R2: writes and readback, R3 plain control
    wr(3'd1, 8'h0F); wr(3'd0, 8'h3C); wr(3'd2, 8'hFF); wr(3'd3, 8'h81); wr(3'd4, 8'h42);
    addr = 3'd1; step(1); cmp("R2", "dir readback", rdata, 8'h0F);
    cmp("R3", "oe from dir", oe, 8'h0F);
    cmp("R3", "do from data", dout, 8'h3C);
    wr(3'd6, 8'hEE); addr = 3'd6; step(1); cmp("R2", "unused read", rdata, 8'h00);
    addr = 3'd2; step(1); cmp("R2", "pull untouched by addr 6", rdata, 8'hFF);
    // R5/R6: timer claim
    t_en = 8'hF0; t_oe = 8'h30; t_do = 8'h20; step(1);
    cmp("R5", "timer direction", oe, 8'h3F);
    cmp("R6", "timer data", dout, 8'h2C);
    // R7/R10: keyboard beats timer
    k_en = 8'h11; step(1);
    cmp("R7", "kbi forces input", oe & 8'h11, 8'h00);
    cmp("R10", "kbi over timer on pin4", oe[4], 1'b0);
    // R8/R10: oscillator beats everything
    k_en = 8'h60; t_en = 8'h60; t_oe = 8'h60; t_do = 8'h60; osc = 1'b1;
    wr(3'd1, 8'hFF); wr(3'd3, 8'hFF); wr(3'd4, 8'hFF);
    step(1);
    cmp("R8", "osc pins dark oe", oe & 8'h60, 8'h00);
    cmp("R8", "osc pins dark drv", dr & 8'h60, 8'h00);
    cmp("R8", "other pins drive", dr & 8'h9F, 8'h9F);
    osc = 1'b0; k_en = '0; step(1);
    cmp("R8", "registers kept after osc", sl, 8'hFF);
    // random mix
    for (int n = 0; n < 3000; n++) begin
      addr = 3'($urandom); we = ($urandom % 4) == 0; wdata = 8'($urandom);
      pin = 8'($urandom); t_en = 8'($urandom); t_oe = 8'($urandom);
      t_do = 8'($urandom); k_en = 8'($urandom) & 8'($urandom);
      osc = ($urandom % 3) == 0;
      step(1);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule